// File: doc/BRIEF.md
# Multi-Channel Timer and PWM Unit

This unit holds eight 16-bit up-counters. Each one can serve as a plain event counter, a periodic timer or a PWM generator. Every channel takes its count clock from one of three sources and passes it through its own prescaler. Both choices live in that channel's control register. The peripheral clock is the block clock itself. The external and real-time sources arrive as single-cycle tick strobes that are already synchronous to it. A counter climbs to its full value and then returns to zero. Its PWM pin rises when the counter wraps and falls when the counter reaches its half value. Each wrap and each half match sets a sticky flag.

One gate register with set and clear aliases starts and stops the clock of every channel. The same register also controls two companion blocks: a watchdog and a 64-bit system timer. Both companions use a control register with the channel layout. The unit only supplies the watchdog's divided tick; the watchdog's own logic sits elsewhere. The system timer counts freely and raises a compare flag. The flags are masked and then merged onto three interrupt lines. Channel 5 has a line of its own. All other channels share one line. The system timer has the third line.

Top module: `timer_pwm_unit`

## Requirements
- R1: After reset every gate bit is 1 (stopped), every mask bit is 1 (masked), all flags are 0, every counter reads 0, all PWM pins are low and all interrupt lines are low.
- R2: Control bits [2:0] are a one-hot source select: bit 0 picks the peripheral clock, bit 1 picks rtc_tick and bit 2 picks ext_tick. Any value that is not one-hot stops counting.
- R3: Control bits [5:3] set the prescale ratio. Values 0 to 5 divide by 1, 4, 16, 64, 256 and 1024, and values 6 and 7 also divide by 1024. Counting starts one clock after the ungating write, so the first tick lands D source ticks later, where D is the ratio.
- R4: The gate state reads at address 0x00. Writing 1s at 0x01 stops units and writing 1s at 0x02 starts them. Bits 0 to 7 are the channels, bit 8 the watchdog and bit 9 the system timer. A stopped counter keeps its value.
- R5: On a tick, a channel whose count equals its full value (offset +1 of its window at 0x10+4*ch) returns to 0 and sets flag bit ch. On any other tick the count increments by one. Offset +3 reads and writes the count, and offset +0 is the control register.
- R6: A tick that brings the count to the half value (offset +2) sets flag bit 8+ch.
- R7: A PWM pin rises when its counter wraps and falls at a half match. While its channel is gated it shows the idle level, which is low.
- R8: The flags read at 0x04. Writing 1 there clears the matching flag and writing 0 has no effect.
- R9: The mask reads at 0x05, with set and clear aliases at 0x06 and 0x07. A mask bit of 1 blocks the matching flag. Mask bits use the same positions as the flags.
- R10: irq_priv is high when an unmasked flag of channel 5 (bit 5 or 13) is set. irq_shared is high when an unmasked flag of any other channel is set.
- R11: The system timer is a 64-bit counter. Its control register is at 0x31, its compare value at 0x32/0x33 and its count at 0x34/0x35 (low word, high word). Each of its ticks adds one, and it sets flag bit 16 on the tick where the count reaches the compare value. irq_sys shows that flag when bit 16 is unmasked.
- R12: The watchdog control register at 0x30 uses the channel layout. wdt_tick pulses once per divided tick while gate bit 8 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_tick | input | 1 | External clock source, one-cycle strobe |
| rtc_tick | input | 1 | Real-time clock source, one-cycle strobe |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | 8 | PWM pin per channel |
| irq_priv | output | 1 | Channel 5 interrupt line |
| irq_shared | output | 1 | Interrupt line shared by the other channels |
| irq_sys | output | 1 | System timer interrupt line |
| wdt_tick | output | 1 | Divided tick for the watchdog |

## Verification
The hardest states to reach are the ones where the prescaler phase, the wrap and the half match all have to line up. A single read of the count cannot show the PWM level or the flags at that point. The random trials therefore run one channel for a random number of edges with random full, half and prescale values. They sample the PWM pin while the channel runs, and then gate the channel so that the count and flags hold still for reading. The bench predicts each result from the tick count. A directed case preloads the system timer just below a 32-bit boundary so that the carry and the compare match happen together within three ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam logic [7:0] A_GATE      = 8'h00;
    localparam logic [7:0] A_GATE_SET  = 8'h01;
    localparam logic [7:0] A_GATE_CLR  = 8'h02;
    localparam logic [7:0] A_FLAG      = 8'h04;
    localparam logic [7:0] A_MASK      = 8'h05;
    localparam logic [7:0] A_MASK_SET  = 8'h06;
    localparam logic [7:0] A_MASK_CLR  = 8'h07;
    localparam logic [7:0] A_CH_BASE   = 8'h10;
    localparam logic [7:0] A_WDT_CTRL  = 8'h30;
    localparam logic [7:0] A_ST_CTRL   = 8'h31;
    localparam logic [7:0] A_ST_CMP_LO = 8'h32;
    localparam logic [7:0] A_ST_CMP_HI = 8'h33;
    localparam logic [7:0] A_ST_CNT_LO = 8'h34;
    localparam logic [7:0] A_ST_CNT_HI = 8'h35;

    localparam int PS_W = 10;

    // Field layout shared by channels, watchdog and system timer
    typedef struct packed {
        logic [2:0] ps;   // [5:3]
        logic [2:0] src;  // [2:0] one-hot: 0 peripheral, 1 rtc, 2 ext
    } ctrl_t;

    function automatic logic [PS_W-1:0] div_last(input logic [2:0] ps);
        logic [PS_W-1:0] r;
        case (ps)
            3'd0:    r = PS_W'(0);
            3'd1:    r = PS_W'(3);
            3'd2:    r = PS_W'(15);
            3'd3:    r = PS_W'(63);
            3'd4:    r = PS_W'(255);
            default: r = PS_W'(1023);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  ext_tick,
    input  logic  rtc_tick,
    input  ctrl_t ctrl,
    output logic  tick
);
    logic [PS_W-1:0] cnt_d, cnt_q;
    logic            src_pulse;
    logic [PS_W-1:0] last;

    always_comb begin
        case (ctrl.src)
            3'b001:  src_pulse = 1'b1;
            3'b010:  src_pulse = rtc_tick;
            3'b100:  src_pulse = ext_tick;
            default: src_pulse = 1'b0;
        endcase
        last  = div_last(ctrl.ps);
        tick  = run && src_pulse && (cnt_q >= last);
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (src_pulse)
            cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int   CW   = 16,
    parameter logic IDLE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          gated,
    input  logic          cnt_we,
    input  logic [CW-1:0] wdata,
    input  logic [CW-1:0] full_val,
    input  logic [CW-1:0] half_val,
    output logic [CW-1:0] count,
    output logic          pwm,
    output logic          full_ev,
    output logic          half_ev
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pwm;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic [CW-1:0] inc;

    always_comb begin
        st_d    = st_q;
        full_ev = 1'b0;
        half_ev = 1'b0;
        inc     = st_q.cnt + 1'b1;
        if (cnt_we) begin
            st_d.cnt = wdata;
        end else if (tick) begin
            if (st_q.cnt == full_val) begin
                st_d.cnt = '0;
                st_d.pwm = 1'b1;
                full_ev  = 1'b1;
            end else begin
                st_d.cnt = inc;
                if (inc == half_val) begin
                    st_d.pwm = 1'b0;
                    half_ev  = 1'b1;
                end
            end
        end
        if (gated) st_d.pwm = IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, pwm: IDLE};
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign pwm   = gated ? IDLE : st_q.pwm;
endmodule

// File: rtl/tmr_systimer.sv
module tmr_systimer #(
    parameter int SW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          we_lo,
    input  logic          we_hi,
    input  logic [31:0]   wdata,
    input  logic [SW-1:0] cmp,
    output logic [SW-1:0] count,
    output logic          match_ev
);
    localparam int HW = SW - 32;

    logic [SW-1:0] cnt_d, cnt_q, inc;

    always_comb begin
        cnt_d    = cnt_q;
        inc      = cnt_q + 1'b1;
        match_ev = 1'b0;
        if (we_lo || we_hi) begin
            if (we_lo) cnt_d[31:0]  = wdata;
            if (we_hi) cnt_d[SW-1:32] = wdata[HW-1:0];
        end else if (tick) begin
            cnt_d    = inc;
            match_ev = (inc == cmp);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/timer_pwm_unit.sv
module timer_pwm_unit
    import tmr_pkg::*;
#(
    parameter int NCH     = 8,
    parameter int CW      = 16,
    parameter int SW      = 64,
    parameter int PRIV_CH = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ext_tick,
    input  logic           rtc_tick,
    input  logic           bus_we,
    input  logic [7:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic [NCH-1:0] pwm_o,
    output logic           irq_priv,
    output logic           irq_shared,
    output logic           irq_sys
    ,
    output logic           wdt_tick
);
    localparam int NU  = NCH + 2;      // channels, watchdog, system timer
    localparam int WDT = NCH;
    localparam int SYS = NCH + 1;
    localparam int FW  = 2 * NCH + 1;  // full flags, half flags, system flag
    localparam logic [FW-1:0] PRIV_SEL = (FW'(1) << PRIV_CH) | (FW'(1) << (NCH + PRIV_CH));
    localparam logic [FW-1:0] CH_SEL   = {1'b0, {(2*NCH){1'b1}}};
    localparam logic [FW-1:0] GRP_SEL  = CH_SEL & ~PRIV_SEL;

    typedef struct packed {
        logic [NU-1:0]           gate;
        logic [FW-1:0]           flag;
        logic [FW-1:0]           mask;
        ctrl_t [NU-1:0]          ctrl;
        logic [NCH-1:0][CW-1:0]  full;
        logic [NCH-1:0][CW-1:0]  half;
        logic [SW-1:0]           st_cmp;
    } regs_t;

    regs_t r_d, r_q;

    logic [NU-1:0]          tick;
    logic [NCH-1:0]         full_ev, half_ev, cnt_we;
    logic [NCH-1:0][CW-1:0] ch_cnt;
    logic [SW-1:0]          st_cnt;
    logic                   st_ev;
    logic                   st_we_lo, st_we_hi;
    logic [NU-1:0]          gate_now;
    logic [FW-1:0]          flag_now, mask_now;

    assign gate_now = r_q.gate;
    assign flag_now = r_q.flag;
    assign mask_now = r_q.mask;

    // Per-unit clock selection and division
    for (genvar u = 0; u < NU; u++) begin : g_pre
        tmr_prescaler u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (!r_q.gate[u]),
            .ext_tick (ext_tick),
            .rtc_tick (rtc_tick),
            .ctrl     (r_q.ctrl[u]),
            .tick     (tick[u])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign cnt_we[c] = bus_we && (bus_addr == A_CH_BASE + 8'(4*c + 3));
        tmr_channel #(.CW(CW), .IDLE(1'b0)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick[c]),
            .gated    (r_q.gate[c]),
            .cnt_we   (cnt_we[c]),
            .wdata    (bus_wdata[CW-1:0]),
            .full_val (r_q.full[c]),
            .half_val (r_q.half[c]),
            .count    (ch_cnt[c]),
            .pwm      (pwm_o[c]),
            .full_ev  (full_ev[c]),
            .half_ev  (half_ev[c])
        );
    end

    assign st_we_lo = bus_we && (bus_addr == A_ST_CNT_LO);
    assign st_we_hi = bus_we && (bus_addr == A_ST_CNT_HI);

    tmr_systimer #(.SW(SW)) u_sys (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick[SYS]),
        .we_lo    (st_we_lo),
        .we_hi    (st_we_hi),
        .wdata    (bus_wdata),
        .cmp      (r_q.st_cmp),
        .count    (st_cnt),
        .match_ev (st_ev)
    );

    // Next-state of the register file
    always_comb begin
        r_d = r_q;
        if (bus_we) begin
            case (bus_addr)
                A_GATE_SET:  r_d.gate = r_q.gate |  bus_wdata[NU-1:0];
                A_GATE_CLR:  r_d.gate = r_q.gate & ~bus_wdata[NU-1:0];
                A_FLAG:      r_d.flag = r_q.flag & ~bus_wdata[FW-1:0];
                A_MASK_SET:  r_d.mask = r_q.mask |  bus_wdata[FW-1:0];
                A_MASK_CLR:  r_d.mask = r_q.mask & ~bus_wdata[FW-1:0];
                A_WDT_CTRL:  r_d.ctrl[WDT] = bus_wdata[5:0];
                A_ST_CTRL:   r_d.ctrl[SYS] = bus_wdata[5:0];
                A_ST_CMP_LO: r_d.st_cmp[31:0]  = bus_wdata;
                A_ST_CMP_HI: r_d.st_cmp[SW-1:32] = bus_wdata[SW-33:0];
                default: ;
            endcase
            for (int c = 0; c < NCH; c++) begin
                if (bus_addr == A_CH_BASE + 8'(4*c))     r_d.ctrl[c] = bus_wdata[5:0];
                if (bus_addr == A_CH_BASE + 8'(4*c + 1)) r_d.full[c] = bus_wdata[CW-1:0];
                if (bus_addr == A_CH_BASE + 8'(4*c + 2)) r_d.half[c] = bus_wdata[CW-1:0];
            end
        end
        // new events win over a same-cycle clear
        r_d.flag = r_d.flag | {st_ev, half_ev, full_ev};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.gate <= '1;
            r_q.mask <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    // Read path
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_GATE:      bus_rdata[NU-1:0] = r_q.gate;
            A_FLAG:      bus_rdata[FW-1:0] = r_q.flag;
            A_MASK:      bus_rdata[FW-1:0] = r_q.mask;
            A_WDT_CTRL:  bus_rdata[5:0]    = r_q.ctrl[WDT];
            A_ST_CTRL:   bus_rdata[5:0]    = r_q.ctrl[SYS];
            A_ST_CMP_LO: bus_rdata         = r_q.st_cmp[31:0];
            A_ST_CMP_HI: bus_rdata[SW-33:0] = r_q.st_cmp[SW-1:32];
            A_ST_CNT_LO: bus_rdata         = st_cnt[31:0];
            A_ST_CNT_HI: bus_rdata[SW-33:0] = st_cnt[SW-1:32];
            default: ;
        endcase
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == A_CH_BASE + 8'(4*c))     bus_rdata[5:0]    = r_q.ctrl[c];
            if (bus_addr == A_CH_BASE + 8'(4*c + 1)) bus_rdata[CW-1:0] = r_q.full[c];
            if (bus_addr == A_CH_BASE + 8'(4*c + 2)) bus_rdata[CW-1:0] = r_q.half[c];
            if (bus_addr == A_CH_BASE + 8'(4*c + 3)) bus_rdata[CW-1:0] = ch_cnt[c];
        end
    end

    // Interrupt merging
    assign irq_priv   = |(r_q.flag & ~r_q.mask & PRIV_SEL);
    assign irq_shared = |(r_q.flag & ~r_q.mask & GRP_SEL);
    assign irq_sys    = r_q.flag[FW-1] & ~r_q.mask[FW-1];
    assign wdt_tick   = tick[WDT];
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int NCH     = 8,
    parameter int CW      = 16,
    parameter int SW      = 64,
    parameter int PRIV_CH = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_we,
    input logic [7:0]             bus_addr,
    input logic [31:0]            bus_wdata,
    input logic [NCH+1:0]         gate_now,
    input logic [2*NCH:0]         flag_now,
    input logic [2*NCH:0]         mask_now,
    input logic [NCH-1:0][CW-1:0] ch_cnt,
    input logic [SW-1:0]          st_cnt,
    input logic [NCH-1:0]         pwm_o,
    input logic                   irq_priv,
    input logic                   irq_sys
);
    localparam int FW = 2 * NCH + 1;

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R7: gated channel shows idle level
        a_r7_idle_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
            gate_now[c] |-> (pwm_o[c] == 1'b0));
        // R4: stopped counter keeps its value unless written
        a_r4_gated_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_now[c] && !(bus_we && bus_addr == 8'h10 + 8'(4*c + 3)))
            |=> $stable(ch_cnt[c]));
    end

    // R4: clear alias starts the addressed units
    a_r4_gate_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'h02)
        |=> ((gate_now & $past(bus_wdata[NCH+1:0])) == '0));

    // R9: set alias masks the addressed flags
    a_r9_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'h06)
        |=> ((mask_now & $past(bus_wdata[FW-1:0])) == $past(bus_wdata[FW-1:0])));

    // R10: private line needs a flag of its own channel
    a_r10_priv_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_priv |-> (flag_now[PRIV_CH] || flag_now[NCH + PRIV_CH]));

    // R11: system line needs the system flag
    a_r11_sys_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sys |-> flag_now[FW-1]);

    // R11: system counter moves by at most one per cycle when not written
    a_r11_step: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (bus_addr == 8'h34 || bus_addr == 8'h35))
        |=> (st_cnt == $past(st_cnt) || st_cnt == $past(st_cnt) + 1'b1));
endmodule

bind timer_pwm_unit tmr_checker #(.NCH(NCH), .CW(CW), .SW(SW), .PRIV_CH(PRIV_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .gate_now  (gate_now),
    .flag_now  (flag_now),
    .mask_now  (mask_now),
    .ch_cnt    (ch_cnt),
    .st_cnt    (st_cnt),
    .pwm_o     (pwm_o),
    .irq_priv  (irq_priv),
    .irq_sys   (irq_sys)
);

// File: tb/tb_timer_pwm_unit.sv
`timescale 1ns/1ps
module tb_timer_pwm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_tick = 1'b0, rtc_tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pwm_o;
    logic        irq_priv, irq_shared, irq_sys, wdt_tick;

    int checks = 0, errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    timer_pwm_unit dut (
        .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .rtc_tick(rtc_tick),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_o(pwm_o), .irq_priv(irq_priv),
        .irq_shared(irq_shared), .irq_sys(irq_sys), .wdt_tick(wdt_tick)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #0.5 d = bus_rdata;
    endtask

    function automatic int div_of(input int ps);
        return (ps >= 5) ? 1024 : (1 << (2 * ps));
    endfunction

    function automatic logic pwm_model(input int t, input int f, input int h);
        logic p = 1'b0;
        int v = 0;
        for (int k = 0; k < t; k++) begin
            if (v == f) begin v = 0; p = 1'b1; end
            else begin v = v + 1; if (v == h) p = 1'b0; end
        end
        return p;
    endfunction

    // Prepare one channel stopped, zeroed and flag-free
    task automatic setup_ch(input int ch, input logic [5:0] ctl, input int f, input int h);
        wr(8'h01, 32'h3FF);
        wr(8'h10 + 8'(4*ch), {26'd0, ctl});
        wr(8'h11 + 8'(4*ch), 32'(f));
        wr(8'h12 + 8'(4*ch), 32'(h));
        wr(8'h13 + 8'(4*ch), 32'd0);
        wr(8'h04, 32'h1FFFF);
    endtask

    initial begin : wd
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v, v2;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, v); check("R1 gate", v, 32'h3FF);
        rd(8'h05, v); check("R1 mask", v, 32'h1FFFF);
        rd(8'h04, v); check("R1 flags", v, 0);
        rd(8'h13, v); check("R1 count", v, 0);
        check("R1 outputs", {pwm_o, irq_priv, irq_shared, irq_sys}, 0);

        // R4 gate aliases
        wr(8'h02, 32'h005); rd(8'h00, v); check("R4 clear alias", v, 32'h3FA);
        wr(8'h01, 32'h001); rd(8'h00, v); check("R4 set alias", v, 32'h3FB);
        wr(8'h01, 32'h3FF);
        // R9 mask aliases
        wr(8'h07, 32'h20); rd(8'h05, v); check("R9 mask clear", v, 32'h1FFDF);
        wr(8'h06, 32'h20); rd(8'h05, v); check("R9 mask set", v, 32'h1FFFF);

        // Random trials: R3 R5 R6 R7 R4
        for (int trial = 0; trial < 14; trial++) begin
            int ch = $urandom_range(0, 7);
            int f  = $urandom_range(1, 40);
            int h  = $urandom_range(0, f);
            int ps = $urandom_range(0, 2);
            int n  = $urandom_range(0, 150);
            int d  = div_of(ps);
            int t;
            setup_ch(ch, {3'(ps), 3'b001}, f, h);
            wr(8'h02, 32'(1) << ch);
            repeat (n) @(posedge clk);
            #1 check("R7 pwm while running", pwm_o[ch], pwm_model(n / d, f, h));
            wr(8'h01, 32'(1) << ch);
            t = (n + 1) / d;
            check("R7 pwm idle when gated", pwm_o[ch], 1'b0);
            rd(8'h13 + 8'(4*ch), v); check("R3 R5 count", v, 32'(t % (f + 1)));
            rd(8'h04, v2);
            check("R5 full flag", v2[ch], (t >= f + 1));
            check("R6 half flag", v2[8 + ch], (h >= 1 && t >= h));
            repeat (5) @(posedge clk);
            rd(8'h13 + 8'(4*ch), v2); check("R4 hold while stopped", v2, v);
        end

        // R3 top prescale code 7 divides by 1024
        setup_ch(3, {3'd7, 3'b001}, 100, 50);
        wr(8'h02, 32'h8);
        repeat (2047) @(posedge clk);
        wr(8'h01, 32'h8);
        rd(8'h1F, v); check("R3 div 1024 code 7", v, 2);

        // R2 sources
        setup_ch(1, 6'b000_010, 1000, 0);
        wr(8'h02, 32'h2);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk) rtc_tick = 1'b1;
            @(negedge clk) rtc_tick = 1'b0;
        end
        wr(8'h01, 32'h2);
        rd(8'h17, v); check("R2 rtc source", v, 5);
        setup_ch(1, 6'b000_100, 1000, 0);
        wr(8'h02, 32'h2);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk) rtc_tick = 1'b1;
            @(negedge clk) rtc_tick = 1'b0;
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk) ext_tick = 1'b1;
            @(negedge clk) ext_tick = 1'b0;
        end
        wr(8'h01, 32'h2);
        rd(8'h17, v); check("R2 ext source ignores rtc", v, 3);
        setup_ch(1, 6'b000_011, 1000, 0);
        wr(8'h02, 32'h2);
        repeat (20) @(posedge clk);
        wr(8'h01, 32'h2);
        rd(8'h17, v); check("R2 non-one-hot stops", v, 0);

        // R10 R8 interrupt routing and clearing
        setup_ch(5, 6'b000_001, 3, 2);
        wr(8'h02, 32'h20); repeat (6) @(posedge clk); wr(8'h01, 32'h20);
        setup_ch(2, 6'b000_001, 3, 2);
        wr(8'h04, 32'h0);
        wr(8'h02, 32'h04); repeat (2) @(posedge clk); wr(8'h01, 32'h04);
        rd(8'h04, v); check("R6 half only on ch2", v, 32'h0400);
        // ch5 flags were cleared by setup_ch; rerun it
        wr(8'h02, 32'h20); repeat (6) @(posedge clk); wr(8'h01, 32'h20);
        rd(8'h04, v); check("R5 R6 flags ch5 ch2", v, 32'h2420);
        check("R10 all masked", {irq_priv, irq_shared}, 2'b00);
        wr(8'h07, 32'h20);
        #1 check("R10 private line", {irq_priv, irq_shared}, 2'b10);
        wr(8'h07, 32'h400);
        #1 check("R10 shared line", {irq_priv, irq_shared}, 2'b11);
        wr(8'h04, 32'h0);
        rd(8'h04, v); check("R8 write 0 no effect", v, 32'h2420);
        wr(8'h04, 32'h20);
        rd(8'h04, v); check("R8 w1c", v, 32'h2400);
        check("R10 private drops", {irq_priv, irq_shared}, 2'b01);
        wr(8'h06, 32'h1FFFF);

        // R11 system timer carry and compare
        wr(8'h31, 32'h01);
        wr(8'h32, 32'h1); wr(8'h33, 32'h1);
        wr(8'h34, 32'hFFFF_FFFE); wr(8'h35, 32'h0);
        wr(8'h07, 32'h10000);
        wr(8'h02, 32'h200); repeat (2) @(posedge clk); wr(8'h01, 32'h200);
        rd(8'h34, v); rd(8'h35, v2);
        check("R11 64-bit count", {v2, v}, 64'h1_0000_0001);
        rd(8'h04, v); check("R11 compare flag", v[16], 1'b1);
        check("R11 irq_sys", irq_sys, 1'b1);

        // R12 watchdog tick divided by 4
        wr(8'h30, 32'h09);
        wr(8'h02, 32'h100);
        begin
            int pulses = 0;
            for (int k = 0; k < 40; k++) begin
                if (wdt_tick) pulses++;
                @(posedge clk); #1;
            end
            check("R12 wdt ticks", pulses, 10);
        end
        wr(8'h01, 32'h100);
        #1 check("R12 wdt gated", wdt_tick, 1'b0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule